// File: doc/BRIEF.md
# Compare-Match Timer Channel

This block is one counting channel with a compare register. Software reaches it through a small memory-mapped register port that takes word and byte writes. Software loads a compare value and picks one of two modes. It then writes a start strobe. From that point the channel counts one step per clock. Each time the count equals the active compare value, the channel raises a one-clock interrupt pulse.

The two modes behave differently at a match. In interval mode the counter goes back to zero after reaching the compare value, so a compare value of N-1 gives one event every N clocks. In free-running mode the counter keeps counting upward and wraps at its full width. A one-shot delay therefore needs software to stop the channel after the first event.

Start and stop are separate write-only strobes. The stop takes effect a fixed number of clocks after the write. Until then the read-only run bit stays at 1, and software polls that bit to learn when the count has halted. The compare and mode settings are copied into the running channel only when a start is written.

Top module: `cmp_timer_chan`

## Requirements
- R1: After a synchronous active-low reset, the irq output is 0, the channel is stopped and interval mode is selected. Every readable register reads 0.
- R2: The register map is as follows.
  - Offset 0x00 holds the compare value. It is read/write, and each byte is written only when its byte-enable is set.
  - Offset 0x04 returns the count and is read-only.
  - Offset 0x08 is control. Only bit 1 is stored, only through byte lane 0; 1 selects free-running mode.
  - Offset 0x0C returns the run bit in bit 0 and is read-only.
  - Offsets 0x10 (start) and 0x14 (stop) are write-only and read as 0.
  - Read data appears on the clock after the request.
- R3: A start write loads the counter with 0 on the next clock, sets the run bit and then increments the counter once per clock. A start write is a write to offset 0x10 with byte lane 0 enabled and bit 0 set. A start written while the channel is running restarts the count from 0.
- R4: In interval mode the counter goes back to 0 on the clock after it equals the active compare value. A compare value of 0xF gives an irq pulse every 16 clocks, and the first pulse comes 16 clocks after the start takes effect.
- R5: In free-running mode a match does not reload or stop the counter. The counter wraps modulo 2^CNT_W, so the next match comes 2^CNT_W clocks later.
- R6: irq is high for exactly the one clock that follows a clock in which the channel runs and the count equals the active compare value. irq is never high at any other time.
- R7: A stop write halts the count exactly STOP_LAT clocks after the write edge. A stop write is a write to offset 0x14 with byte lane 0 enabled and bit 0 set. Until the halt, the run bit keeps reading 1. After the halt the counter holds its value. A stop written while the channel is stopped has no effect.
- R8: Writes to the compare or control register while the channel runs leave the running period and mode unchanged. The new values take effect at the next start.
- R9: All CNT_W bits of the compare value are honoured. With compare 0xFFFFFFFF in interval mode, the counter runs well past 0xF with no reload and no irq.
- R10: A start written while a stop is still pending cancels the stop, and the channel keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Register access request, one clock per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | High on the clock after a read request |
| irq | output | 1 | One-clock compare-event pulse |

## Verification
The hardest situation to reach from the ports is the window between a stop write and the actual halt, while the run bit still reads 1. The stimulus places reads of the run bit and of the counter on each clock of that window. It also places a second start inside the window, to show that the pending stop is dropped. Proving counter wrap-around at full width would take 2^32 clocks. A second instance built with an 8-bit counter reaches the wrap within a few hundred clocks.

// File: rtl/cmt_pkg.sv
`timescale 1ns/1ps
package cmt_pkg;
   localparam int BUS_W = 32;
   localparam int OFS_W = 8;
   localparam int BE_W  = BUS_W / 8;

   // Register offsets (byte addresses)
   localparam logic [OFS_W-1:0] OFS_CMP   = 8'h00;
   localparam logic [OFS_W-1:0] OFS_CNT   = 8'h04;
   localparam logic [OFS_W-1:0] OFS_CTL   = 8'h08;
   localparam logic [OFS_W-1:0] OFS_STAT  = 8'h0C;
   localparam logic [OFS_W-1:0] OFS_START = 8'h10;
   localparam logic [OFS_W-1:0] OFS_STOP  = 8'h14;

   localparam int CTL_MODE_BIT = 1;

   typedef enum logic {
      MODE_INTERVAL = 1'b0,
      MODE_FREERUN  = 1'b1
   } cmt_mode_e;
endpackage

// File: rtl/cmt_regif.sv
`timescale 1ns/1ps
module cmt_regif
   import cmt_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_req,
   input  logic                  bus_we,
   input  logic [OFS_W-1:0]      bus_addr,
   input  logic [BE_W-1:0]       bus_be,
   input  logic [BUS_W-1:0]      bus_wdata,
   input  logic [CNT_W-1:0]      cnt_val,
   input  logic                  run_stat,
   output logic [BUS_W-1:0]      bus_rdata,
   output logic                  bus_rvalid,
   output logic [CNT_W-1:0]      cmp_sw,
   output cmt_mode_e             mode_sw,
   output logic                  start_req,
   output logic                  stop_req
);
   localparam logic [BUS_W-1:0] CMP_MASK = BUS_W'((64'd1 << CNT_W) - 64'd1);

   logic [BUS_W-1:0] cmp_q;
   cmt_mode_e        mode_q;
   logic [BUS_W-1:0] rd_mux;
   logic             wr_any;
   logic             cmp_wr;
   logic             ctl_wr;

   assign wr_any    = bus_req && bus_we;
   assign cmp_wr    = wr_any && (bus_addr == OFS_CMP);
   assign ctl_wr    = wr_any && (bus_addr == OFS_CTL) && bus_be[0];
   assign start_req = wr_any && (bus_addr == OFS_START) && bus_be[0] && bus_wdata[0];
   assign stop_req  = wr_any && (bus_addr == OFS_STOP)  && bus_be[0] && bus_wdata[0];

   // Compare register, per-byte write enables
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_q <= '0;
      end else if (cmp_wr) begin
         for (int b = 0; b < BE_W; b++) begin
            if (bus_be[b]) cmp_q[8*b +: 8] <= bus_wdata[8*b +: 8] & CMP_MASK[8*b +: 8];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      mode_q <= MODE_INTERVAL;
      else if (ctl_wr) mode_q <= cmt_mode_e'(bus_wdata[CTL_MODE_BIT]);
   end

   assign cmp_sw  = cmp_q[CNT_W-1:0];
   assign mode_sw = mode_q;

   always_comb begin
      rd_mux = '0;
      case (bus_addr)
         OFS_CMP:  rd_mux = cmp_q;
         OFS_CNT:  rd_mux[CNT_W-1:0] = cnt_val;
         OFS_CTL:  rd_mux[CTL_MODE_BIT] = mode_q;
         OFS_STAT: rd_mux[0] = run_stat;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata  <= '0;
         bus_rvalid <= 1'b0;
      end else begin
         bus_rvalid <= bus_req && !bus_we;
         if (bus_req && !bus_we) bus_rdata <= rd_mux;
      end
   end
endmodule

// File: rtl/cmt_core.sv
`timescale 1ns/1ps
module cmt_core
   import cmt_pkg::*;
#(
   parameter int CNT_W    = 32,
   parameter int STOP_LAT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req,
   input  logic             stop_req,
   input  logic [CNT_W-1:0] cmp_sw,
   input  cmt_mode_e        mode_sw,
   output logic [CNT_W-1:0] cnt_q,
   output logic             run_q,
   output logic             match,
   output logic [CNT_W-1:0] cmp_act,
   output cmt_mode_e        mode_act
);
   logic [STOP_LAT-1:0] stop_pipe;
   logic                halt_now;

   // Stop delay line: a variant per latency
   if (STOP_LAT == 1) begin : g_stop_one
      always_ff @(posedge clk) begin
         if (!rst_n || start_req || halt_now) stop_pipe <= '0;
         else if (run_q)                      stop_pipe <= stop_req;
      end
   end else begin : g_stop_multi
      always_ff @(posedge clk) begin
         if (!rst_n || start_req || halt_now) stop_pipe <= '0;
         else if (run_q)                      stop_pipe <= {stop_pipe[STOP_LAT-2:0], stop_req};
      end
   end

   assign halt_now = stop_pipe[STOP_LAT-1];
   assign match    = run_q && (cnt_q == cmp_act);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         run_q    <= 1'b0;
         cmp_act  <= '0;
         mode_act <= MODE_INTERVAL;
      end else if (start_req) begin
         cnt_q    <= '0;
         run_q    <= 1'b1;
         cmp_act  <= cmp_sw;
         mode_act <= mode_sw;
      end else if (run_q) begin
         if (halt_now) begin
            run_q <= 1'b0;
         end else if ((mode_act == MODE_INTERVAL) && (cnt_q == cmp_act)) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/cmt_irq.sv
`timescale 1ns/1ps
module cmt_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic match,
   output logic irq
);
   always_ff @(posedge clk) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= match;
   end
endmodule

// File: rtl/cmp_timer_chan.sv
`timescale 1ns/1ps
module cmp_timer_chan #(
   parameter int CNT_W    = 32,
   parameter int STOP_LAT = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_req,
   input  logic        bus_we,
   input  logic [7:0]  bus_addr,
   input  logic [3:0]  bus_be,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        bus_rvalid,
   output logic        irq
);
   import cmt_pkg::*;

   if (CNT_W < 8 || CNT_W > BUS_W) begin : g_bad_cnt_w
      initial $fatal(1, "cmp_timer_chan: CNT_W must lie in 8..32");
   end
   if (STOP_LAT < 1 || STOP_LAT > 8) begin : g_bad_stop_lat
      initial $fatal(1, "cmp_timer_chan: STOP_LAT must lie in 1..8");
   end

   logic [CNT_W-1:0] cmp_sw;
   cmt_mode_e        mode_sw;
   logic             start_req;
   logic             stop_req;
   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic             match;
   logic [CNT_W-1:0] cmp_act;
   cmt_mode_e        mode_act;

   cmt_regif #(.CNT_W(CNT_W)) u_regif (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_req   (bus_req),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_be    (bus_be),
      .bus_wdata (bus_wdata),
      .cnt_val   (cnt_q),
      .run_stat  (run_q),
      .bus_rdata (bus_rdata),
      .bus_rvalid(bus_rvalid),
      .cmp_sw    (cmp_sw),
      .mode_sw   (mode_sw),
      .start_req (start_req),
      .stop_req  (stop_req)
   );

   cmt_core #(.CNT_W(CNT_W), .STOP_LAT(STOP_LAT)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_req(start_req),
      .stop_req (stop_req),
      .cmp_sw   (cmp_sw),
      .mode_sw  (mode_sw),
      .cnt_q    (cnt_q),
      .run_q    (run_q),
      .match    (match),
      .cmp_act  (cmp_act),
      .mode_act (mode_act)
   );

   cmt_irq u_irq (
      .clk  (clk),
      .rst_n(rst_n),
      .match(match),
      .irq  (irq)
   );
endmodule

// File: rtl/cmt_chk.sv
`timescale 1ns/1ps
module cmt_chk
   import cmt_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_req,
   input logic             stop_req,
   input logic             run_q,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] cmp_act,
   input cmt_mode_e        mode_act,
   input logic             irq
);
   a_r3_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      start_req |=> (run_q && (cnt_q == '0)));

   a_r7_stop_holds_run: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req && run_q && !start_req) |=> run_q);

   a_r6_irq_after_run: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(run_q));

   a_r5_free_increment: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && run_q && $past(run_q) && !$past(start_req) && (mode_act == MODE_FREERUN))
      |-> (cnt_q == $past(cnt_q) + CNT_W'(1)));

   a_r8_active_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !start_req) |=> ($stable(cmp_act) && $stable(mode_act)));

   a_r4_interval_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !start_req && (mode_act == MODE_INTERVAL) && (cnt_q == cmp_act))
      |=> (!run_q || (cnt_q == '0)));
endmodule

bind cmp_timer_chan cmt_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_req(start_req),
   .stop_req (stop_req),
   .run_q    (run_q),
   .cnt_q    (cnt_q),
   .cmp_act  (cmp_act),
   .mode_act (mode_act),
   .irq      (irq)
);

// File: tb/cmp_timer_chan_bench.sv
`timescale 1ns/1ps
module cmp_timer_chan_bench;
   localparam int STOP_LAT = 2;
   localparam logic [7:0] A_CMP = 8'h00, A_CNT = 8'h04, A_CTL = 8'h08,
                          A_STAT = 8'h0C, A_START = 8'h10, A_STOP = 8'h14;

   // {addr[7:0], be[3:0], wdata[31:0], expected readback[31:0]}
   localparam int N_VEC = 11;
   localparam logic [75:0] VEC [N_VEC] = '{
      {8'h00, 4'hF, 32'h11223344, 32'h11223344},
      {8'h00, 4'h4, 32'h00AA0000, 32'h11AA3344},
      {8'h00, 4'h1, 32'h000000FF, 32'h11AA33FF},
      {8'h08, 4'h1, 32'h000000FF, 32'h00000002},
      {8'h08, 4'h1, 32'h00000000, 32'h00000000},
      {8'h08, 4'hE, 32'h00000002, 32'h00000000},
      {8'h04, 4'hF, 32'h12345678, 32'h00000000},
      {8'h0C, 4'hF, 32'h00000001, 32'h00000000},
      {8'h14, 4'h1, 32'h00000001, 32'h00000000},
      {8'h10, 4'h2, 32'h00000101, 32'h00000000},
      {8'h0C, 4'h0, 32'h00000000, 32'h00000000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic        sel = 1'b0;
   logic [31:0] rdata_b, rdata_s;
   logic        rvalid_b, rvalid_s, irq_b, irq_s;
   logic        req_b, req_s;
   logic        done = 1'b0;
   int          checks = 0;
   int          errors = 0;

   always #10 clk = ~clk;

   assign req_b = bus_req && !sel;
   assign req_s = bus_req && sel;

   cmp_timer_chan #(.CNT_W(32), .STOP_LAT(STOP_LAT)) u_cmp_timer_chan (
      .clk(clk), .rst_n(rst_n), .bus_req(req_b), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .bus_rvalid(rvalid_b),
      .irq(irq_b));

   cmp_timer_chan #(.CNT_W(8), .STOP_LAT(STOP_LAT)) u_small (
      .clk(clk), .rst_n(rst_n), .bus_req(req_s), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(rdata_s), .bus_rvalid(rvalid_s),
      .irq(irq_s));

   function automatic logic cur_irq();
      return sel ? irq_s : irq_b;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // All bus tasks start and end on a falling edge.
   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
      @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0; bus_be = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic v);
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_req = 1'b0;
      d = sel ? rdata_s : rdata_b;
      v = sel ? rvalid_s : rvalid_b;
   endtask

   task automatic wait_irq(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!cur_irq() && n < 1000);
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      logic [31:0] got;
      logic        v;
      int          n;
      logic        seen;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state, both instances
      chk("R1 irq", {31'd0, irq_b}, 32'd0);
      rd(A_CMP, got, v);  chk("R1 cmp", got, 32'd0);
      rd(A_CNT, got, v);  chk("R1 cnt", got, 32'd0);
      rd(A_CTL, got, v);  chk("R1 ctl interval", got, 32'd0);
      rd(A_STAT, got, v); chk("R1 stopped", got, 32'd0);
      sel = 1'b1;
      rd(A_CTL, got, v);  chk("R1 small ctl", got, 32'd0);
      sel = 1'b0;

      // R2: register map table
      for (int i = 0; i < N_VEC; i++) begin
         wr(VEC[i][75:68], VEC[i][63:32], VEC[i][67:64]);
         rd(VEC[i][75:68], got, v);
         chk("R2 readback", got, VEC[i][31:0]);
         chk("R2 rvalid", {31'd0, v}, 32'd1);
      end

      // R4/R6: interval mode, compare 0xF
      wr(A_CMP, 32'h0000000F, 4'hF);
      wr(A_START, 32'h1, 4'h1);
      wait_irq(n); chk("R4 first delay", n, 32'd16);
      @(negedge clk); chk("R6 single pulse", {31'd0, irq_b}, 32'd0);
      wait_irq(n); chk("R4 period", n, 32'd15);
      wait_irq(n); chk("R4 period", n, 32'd16);

      // R8: writes while running wait for the next start
      wr(A_CMP, 32'h7, 4'hF);
      wr(A_CTL, 32'h2, 4'h1);
      wait_irq(n);
      wait_irq(n); chk("R8 period unchanged", n, 32'd16);
      wr(A_START, 32'h1, 4'h1);
      wait_irq(n); chk("R8 new cmp at start", n, 32'd8);

      // R5: free running past the match
      rd(A_CNT, got, v); chk("R5 no reload", got, 32'd8);
      repeat (20) @(negedge clk);
      rd(A_CNT, got, v); chk("R5 keeps counting", got, 32'd29);

      // R3: restart while running
      wr(A_START, 32'h1, 4'h1);
      rd(A_CNT, got, v); chk("R3 restart zero", got, 32'd0);
      repeat (4) @(negedge clk);
      rd(A_CNT, got, v); chk("R3 counting", got, 32'd5);
      rd(A_STAT, got, v); chk("R3 running", got, 32'd1);

      // R7: stop handshake
      wr(A_START, 32'h1, 4'h1);
      repeat (9) @(negedge clk);
      wr(A_STOP, 32'h1, 4'h1);
      rd(A_STAT, got, v); chk("R7 busy 1", got, 32'd1);
      rd(A_STAT, got, v); chk("R7 busy 2", got, 32'd1);
      rd(A_STAT, got, v); chk("R7 halted", got, 32'd0);
      rd(A_CNT, got, v);  chk("R7 final count", got, 32'd9 + STOP_LAT);
      repeat (5) @(negedge clk);
      rd(A_CNT, got, v);  chk("R7 count held", got, 32'd9 + STOP_LAT);
      wr(A_STOP, 32'h1, 4'h1);
      rd(A_STAT, got, v); chk("R7 stop when idle", got, 32'd0);
      rd(A_CNT, got, v);  chk("R7 idle count", got, 32'd9 + STOP_LAT);

      // R10: start during a pending stop
      wr(A_START, 32'h1, 4'h1);
      repeat (3) @(negedge clk);
      wr(A_STOP, 32'h1, 4'h1);
      wr(A_START, 32'h1, 4'h1);
      rd(A_STAT, got, v); chk("R10 still running", got, 32'd1);
      rd(A_CNT, got, v);  chk("R10 restarted", got, 32'd1);
      repeat (6) @(negedge clk);
      rd(A_STAT, got, v); chk("R10 stop dropped", got, 32'd1);

      // R9: full-width compare, interval mode
      wr(A_CMP, 32'hFFFFFFFF, 4'hF);
      wr(A_CTL, 32'h0, 4'h1);
      wr(A_START, 32'h1, 4'h1);
      seen = 1'b0;
      for (int i = 0; i < 39; i++) begin
         @(negedge clk);
         if (irq_b) seen = 1'b1;
      end
      chk("R9 no irq", {31'd0, seen}, 32'd0);
      rd(A_CNT, got, v); chk("R9 past 0xF", got, 32'd39);
      wr(A_STOP, 32'h1, 4'h1);

      // R5: wrap on the 8-bit instance
      sel = 1'b1;
      wr(A_CMP, 32'h3, 4'hF);
      wr(A_CTL, 32'h2, 4'h1);
      wr(A_START, 32'h1, 4'h1);
      wait_irq(n); chk("R6 first match", n, 32'd4);
      wait_irq(n); chk("R5 wrap period", n, 32'd256);
      rd(A_CNT, got, v); chk("R5 after wrap", got, 32'd4);
      sel = 1'b0;

      done = 1'b1;
      finish_run();
   end
endmodule